// File: doc/BRIEF.md
# DMA Controller Control Ports and Request Scanner

This block holds the controller-wide state of a four-channel DMA controller: one command byte, a mode byte for each channel, a channel mask, and a status byte. The lower status nibble holds terminal-count flags and the upper nibble holds pending requests. Software reaches this state through eight control indices (8 to 15) on a small port bus. A neighbouring channel register block and the transfer engine use its outputs.

Each cycle the block scans the channels. A channel is eligible for service when its request bit is set and its mask bit is clear. Eligibility is driven as registered service-enable lines. The block also gives a one-hot grant to the lowest-numbered eligible channel and the transfer length of that channel. The length is the base count plus one, shifted left by the controller index, so it is counted in bytes for an 8-bit or a 16-bit controller. Requests come from hardware hold and release strobes or from software request writes. Terminal-count flags come from the channel block. A byte-pointer clear and a master reset leave the block as one-cycle pulses.

Port indices 0 to 7 belong to the channel register block. On this block they write nothing and read zero.

Top module: `dma_ctl_scan`

## Requirements
- R1: After power-on reset the mask is all ones (`0x0F` when read) and status, command and all mode bytes are zero. All service, grant, length and pulse outputs are low.
- R2: A write to index 8 stores the command only if the byte is `0x00` or `0x04`. Any other byte leaves the command unchanged.
- R3: A write to index 9 selects channel `data[1:0]`. It sets or clears request bit `4+ch` as `data[2]` gives, and it always clears terminal-count bit `ch`.
- R4: A write to index 10 sets or clears mask bit `data[1:0]` as `data[2]` gives.
- R5: A write to index 11 stores the whole byte as the mode of channel `data[1:0]`. The direction output for that channel is mode bit 5 (1 = decrement), and the operating-mode output is mode bits 7:6.
- R6: A write to index 12 gives a one-cycle byte-pointer clear pulse in the cycle after the write edge. A write to index 13 gives that pulse plus a one-cycle master reset pulse, and sets the mask to all ones and status and command to zero.
- R7: A write to index 14 clears all mask bits. A write to index 15 loads the mask from `data[3:0]`.
- R8: Reads are combinational. Index 8 returns status as {request[3:0], terminal-count[3:0]}, and the terminal-count nibble is cleared at the edge that ends the read. Index 15 returns the mask zero-extended. Every other index returns 0. Writes to indices 0 to 7 change no state.
- R9: A hold strobe sets the request bit of its channel and a release strobe clears it. Hold wins when both arrive together. A software write to index 9 in the same cycle overrides the strobes for the channel it names.
- R10: A terminal-count strobe sets its status bit. It wins over a clear by a status read or a request write in the same cycle. A master reset wins over it.
- R11: The service-enable bit of a channel is high one cycle after its request bit is set while its mask bit is clear, and it follows any later change with the same one-cycle delay.
- R12: The grant is the lowest-numbered channel with service enabled, one-hot, registered with the service enables. The length output is `(base_count[grant] + 1) << CTRL_IDX` and is zero when there is no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, same state as a master reset |
| port_wr | input | 1 | Write strobe for the port bus |
| port_rd | input | 1 | Read strobe for the port bus |
| port_idx | input | 4 | Port index after scaling |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data, combinational |
| dreq_hold | input | 4 | Per-channel request set strobes |
| dreq_release | input | 4 | Per-channel request clear strobes |
| tc_set | input | 4 | Per-channel terminal-count strobes |
| base_cnt | input | 64 | Base counts of channels 0 to 3, 16 bits each, channel 0 lowest |
| cmd_reg | output | 8 | Accepted command byte |
| mode_flat | output | 32 | Mode bytes, channel 0 lowest |
| dir_dec | output | 4 | Per-channel decrement flag |
| op_mode | output | 8 | Per-channel operating mode, 2 bits each |
| svc_en | output | 4 | Registered per-channel service enables |
| svc_grant | output | 4 | One-hot lowest eligible channel |
| svc_len | output | 18 | Transfer length of the granted channel |
| ptr_clr | output | 1 | Byte-pointer clear pulse |
| mst_rst | output | 1 | Master reset pulse |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions on one status bit. These are a release strobe against a software request write, a hold against a release, and a terminal-count strobe against the clear done by a status read. The bench drives each pair in one cycle, holding both inputs across the same clock edge, and then reads the status port back. It also checks the priority grant with two channels eligible and with the largest base count, where the add and the shift carry into the top bits of the length.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  typedef enum logic [3:0] {
    IX_CMD   = 4'd8,
    IX_REQ   = 4'd9,
    IX_SMASK = 4'd10,
    IX_MODE  = 4'd11,
    IX_FFCLR = 4'd12,
    IX_MRST  = 4'd13,
    IX_MCLR  = 4'd14,
    IX_MALL  = 4'd15
  } ctl_idx_e;

  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic ffclr;
    logic mrst;
    logic mclr;
    logic mall;
    logic rd_stat;
    logic rd_mask;
  } ctl_ev_t;

  // command byte is legal only when nothing but the controller-disable bit is set
  function automatic logic cmd_legal(input logic [7:0] b);
    return (b & 8'hFB) == 8'h00;
  endfunction

  function automatic logic [3:0] first_one(input logic [3:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 3; i >= 0; i--)
      if (v[i]) r = 4'(1) << i;
    return r;
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_ctl_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx,
  output ctl_ev_t          ev
);
  logic is_ctl;
  assign is_ctl = idx[IDX_W-1];

  always_comb begin
    ev = '0;
    if (is_ctl && wr) begin
      unique case (idx[3:0])
        IX_CMD:   ev.cmd   = 1'b1;
        IX_REQ:   ev.req   = 1'b1;
        IX_SMASK: ev.smask = 1'b1;
        IX_MODE:  ev.mode  = 1'b1;
        IX_FFCLR: ev.ffclr = 1'b1;
        IX_MRST:  ev.mrst  = 1'b1;
        IX_MCLR:  ev.mclr  = 1'b1;
        IX_MALL:  ev.mall  = 1'b1;
        default:  ;
      endcase
    end
    if (is_ctl && rd) begin
      ev.rd_stat = (idx[3:0] == IX_CMD);
      ev.rd_mask = (idx[3:0] == IX_MALL);
    end
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctl_ev_t                  ev,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH-1:0]        dreq_hold,
  input  logic [NUM_CH-1:0]        dreq_release,
  input  logic [NUM_CH-1:0]        tc_set,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [NUM_CH-1:0]        req_o,
  output logic [DATA_W-1:0]        cmd_o,
  output logic [NUM_CH*DATA_W-1:0] mode_o,
  output logic                     ptr_clr_o,
  output logic                     mst_rst_o
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int SETBIT = CH_W;

  logic [NUM_CH-1:0] mask_q, mask_n, req_q, req_n, tc_q, tc_n;
  logic [DATA_W-1:0] cmd_q, cmd_n;
  logic [CH_W-1:0]   sel_ch;
  logic              cmd_reject;

  assign sel_ch     = wdata[CH_W-1:0];
  assign cmd_reject = ev.cmd && !cmd_legal(wdata[7:0]);

  always_comb begin
    mask_n = mask_q;
    cmd_n  = cmd_q;
    req_n  = (req_q & ~dreq_release) | dreq_hold;
    tc_n   = tc_q;
    if (ev.rd_stat) tc_n = '0;
    if (ev.req) begin
      req_n[sel_ch] = wdata[SETBIT];
      tc_n[sel_ch]  = 1'b0;
    end
    tc_n = tc_n | tc_set;
    if (ev.smask) mask_n[sel_ch] = wdata[SETBIT];
    if (ev.mclr)  mask_n = '0;
    if (ev.mall)  mask_n = wdata[NUM_CH-1:0];
    if (ev.cmd && !cmd_reject) cmd_n = wdata;
    if (ev.mrst) begin
      mask_n = '1;
      req_n  = '0;
      tc_n   = '0;
      cmd_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      req_q     <= '0;
      tc_q      <= '0;
      cmd_q     <= '0;
      ptr_clr_o <= 1'b0;
      mst_rst_o <= 1'b0;
    end else begin
      mask_q    <= mask_n;
      req_q     <= req_n;
      tc_q      <= tc_n;
      cmd_q     <= cmd_n;
      ptr_clr_o <= ev.ffclr | ev.mrst;
      mst_rst_o <= ev.mrst;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_mode
      logic [DATA_W-1:0] mode_q;
      logic              hit;
      assign hit = ev.mode && (sel_ch == CH_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mode_q <= '0;
        else if (hit)   mode_q <= wdata;
      end
      assign mode_o[g*DATA_W +: DATA_W] = mode_q;

      assert_mode_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> mode_q == $past(wdata));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (ev.rd_stat) rdata = DATA_W'({req_q, tc_q});
    if (ev.rd_mask) rdata = DATA_W'(mask_q);
  end

  assign mask_o = mask_q;
  assign req_o  = req_q;
  assign cmd_o  = cmd_q;

  assert_cmd_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> $stable(cmd_q));
  assert_mrst_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev.mrst |=> (&mask_q) && req_q == '0 && tc_q == '0 && cmd_q == '0 && mst_rst_o && ptr_clr_o);
  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rd_stat && tc_set == '0) |=> tc_q == '0);
  assert_tc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0 && !ev.mrst) |=> (tc_q & $past(tc_set)) == $past(tc_set));
  assert_hold_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_hold != '0 && !ev.req && !ev.mrst) |=> (req_q & $past(dreq_hold)) == $past(dreq_hold));
endmodule

// File: rtl/dma_req_scan.sv
module dma_req_scan
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 16,
  parameter int CTRL_IDX = 0,
  parameter int LEN_W    = CNT_W + 1 + CTRL_IDX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic [NUM_CH-1:0]       req_i,
  input  logic [NUM_CH*CNT_W-1:0] base_cnt,
  output logic [NUM_CH-1:0]       svc_en,
  output logic [NUM_CH-1:0]       grant,
  output logic [LEN_W-1:0]        len
);
  logic [NUM_CH-1:0] elig, pick;
  logic [LEN_W-1:0]  len_n;

  function automatic logic [LEN_W-1:0] xfer_len(input logic [CNT_W-1:0] c);
    logic [LEN_W-1:0] w;
    w = LEN_W'(c) + LEN_W'(1);
    return w << CTRL_IDX;
  endfunction

  assign elig = ~mask_i & req_i;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (elig[i]) pick = NUM_CH'(1) << i;
  end

  always_comb begin
    len_n = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (pick[i]) len_n = xfer_len(base_cnt[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_en <= '0;
      grant  <= '0;
      len    <= '0;
    end else begin
      svc_en <= elig;
      grant  <= pick;
      len    <= len_n;
    end
  end

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_in_svc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~svc_en) == '0);
  assert_len_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> len == '0);
  assert_masked_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |=> svc_en == '0);
  assert_svc_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i != '0 && mask_i == '0) |=> svc_en != '0);
endmodule

// File: rtl/dma_ctl_scan.sv
module dma_ctl_scan
  import dma_ctl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 16,
  parameter int CTRL_IDX = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          port_wr,
  input  logic                          port_rd,
  input  logic [IDX_W-1:0]              port_idx,
  input  logic [DATA_W-1:0]             port_wdata,
  output logic [DATA_W-1:0]             port_rdata,
  input  logic [NUM_CH-1:0]             dreq_hold,
  input  logic [NUM_CH-1:0]             dreq_release,
  input  logic [NUM_CH-1:0]             tc_set,
  input  logic [NUM_CH*CNT_W-1:0]       base_cnt,
  output logic [DATA_W-1:0]             cmd_reg,
  output logic [NUM_CH*DATA_W-1:0]      mode_flat,
  output logic [NUM_CH-1:0]             dir_dec,
  output logic [NUM_CH*2-1:0]           op_mode,
  output logic [NUM_CH-1:0]             svc_en,
  output logic [NUM_CH-1:0]             svc_grant,
  output logic [CNT_W+CTRL_IDX:0]       svc_len,
  output logic                          ptr_clr,
  output logic                          mst_rst
);
  localparam int LEN_W   = CNT_W + 1 + CTRL_IDX;
  localparam int DIR_BIT = 5;
  localparam int OPM_LSB = 6;

  ctl_ev_t           ev;
  logic [NUM_CH-1:0] mask_w, req_w;

  dma_port_decode #(.IDX_W(IDX_W)) u_dec (
    .wr(port_wr), .rd(port_rd), .idx(port_idx), .ev(ev)
  );

  dma_ctl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wdata(port_wdata),
    .dreq_hold(dreq_hold), .dreq_release(dreq_release), .tc_set(tc_set),
    .rdata(port_rdata), .mask_o(mask_w), .req_o(req_w), .cmd_o(cmd_reg),
    .mode_o(mode_flat), .ptr_clr_o(ptr_clr), .mst_rst_o(mst_rst)
  );

  dma_req_scan #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CTRL_IDX(CTRL_IDX), .LEN_W(LEN_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .mask_i(mask_w), .req_i(req_w),
    .base_cnt(base_cnt), .svc_en(svc_en), .grant(svc_grant), .len(svc_len)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_modebits
      assign dir_dec[g]        = mode_flat[g*DATA_W + DIR_BIT];
      assign op_mode[g*2 +: 2] = mode_flat[g*DATA_W + OPM_LSB +: 2];
    end
  endgenerate

  assert_rst_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_rst) |-> (&mask_w));
endmodule

// File: tb/sim_dma_ctl_scan.sv
`timescale 1ns/1ps
module sim_dma_ctl_scan;
  logic        clk = 0, rst_n = 0;
  logic        port_wr = 0, port_rd = 0;
  logic [3:0]  port_idx = 0;
  logic [7:0]  port_wdata = 0, port_rdata;
  logic [3:0]  dreq_hold = 0, dreq_release = 0, tc_set = 0;
  logic [63:0] base_cnt;
  logic [7:0]  cmd_reg, op_mode;
  logic [31:0] mode_flat;
  logic [3:0]  dir_dec, svc_en, svc_grant;
  logic [17:0] svc_len;
  logic        ptr_clr, mst_rst;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  assign base_cnt = {16'h0007, 16'hFFFF, 16'h0010, 16'h0005};

  always #4 clk = ~clk;

  dma_ctl_scan #(.CTRL_IDX(1)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); port_wr = 1; port_idx = i; port_wdata = d;
    @(negedge clk); port_wr = 0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] d);
    @(negedge clk); port_rd = 1; port_idx = i; #1 d = port_rdata;
    @(negedge clk); port_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'd15, d); chk("R1 mask", d, 8'h0F);
    rd(4'd8, d);  chk("R1 status", d, 8'h00);
    chk("R1 cmd", cmd_reg, 0); chk("R1 modes", mode_flat, 0);
    chk("R1 svc", {svc_en, svc_grant}, 0); chk("R1 len", svc_len, 0);
    chk("R1 pulses", {ptr_clr, mst_rst}, 0);
  endtask

  task automatic t_cmd;
    wr(4'd8, 8'h04); chk("R2 accept 04", cmd_reg, 8'h04);
    wr(4'd8, 8'h10); chk("R2 reject 10", cmd_reg, 8'h04);
    wr(4'd8, 8'h00); chk("R2 accept 00", cmd_reg, 8'h00);
    wr(4'd8, 8'h84); chk("R2 reject 84", cmd_reg, 8'h00);
  endtask

  task automatic t_req_mask;
    logic [7:0] d;
    wr(4'd14, 8'h00);
    wr(4'd9, 8'h06);
    chk("R11 not yet", svc_en, 4'b0000);
    rd(4'd8, d); chk("R3 req set", d, 8'h40);
    chk("R11 svc on", svc_en, 4'b0100);
    chk("R12 grant ch2", svc_grant, 4'b0100);
    chk("R12 len max", svc_len, 18'h20000);
    wr(4'd10, 8'h06); @(negedge clk);
    chk("R4 mask ch2", svc_en, 4'b0000);
    wr(4'd10, 8'h02); @(negedge clk);
    chk("R4 unmask ch2", svc_en, 4'b0100);
    wr(4'd15, 8'h0A); rd(4'd15, d); chk("R7 mask write", d, 8'h0A);
    wr(4'd14, 8'h55); rd(4'd15, d); chk("R7 mask clear", d, 8'h00);
    wr(4'd9, 8'h02);
  endtask

  task automatic t_prio;
    wr(4'd9, 8'h07); wr(4'd9, 8'h05); @(negedge clk);
    chk("R12 two eligible", svc_en, 4'b1010);
    chk("R12 lowest wins", svc_grant, 4'b0010);
    chk("R12 len ch1", svc_len, 18'h22);
    wr(4'd9, 8'h01); @(negedge clk);
    chk("R12 grant ch3", svc_grant, 4'b1000);
    chk("R12 len ch3", svc_len, 18'h10);
    wr(4'd9, 8'h03);
  endtask

  task automatic t_dreq;
    logic [7:0] d;
    @(negedge clk); dreq_hold = 4'b0001;
    @(negedge clk); dreq_hold = 0;
    rd(4'd8, d); chk("R9 hold", d, 8'h10);
    @(negedge clk); dreq_hold = 4'b0001; dreq_release = 4'b0001;
    @(negedge clk); dreq_hold = 0; dreq_release = 0;
    rd(4'd8, d); chk("R9 hold beats release", d, 8'h10);
    @(negedge clk); dreq_release = 4'b0011; port_wr = 1; port_idx = 4'd9; port_wdata = 8'h05;
    @(negedge clk); dreq_release = 0; port_wr = 0;
    rd(4'd8, d); chk("R9 port beats strobe", d, 8'h20);
    @(negedge clk); dreq_release = 4'b0010;
    @(negedge clk); dreq_release = 0;
    rd(4'd8, d); chk("R9 release", d, 8'h00);
  endtask

  task automatic t_tc;
    logic [7:0] d;
    @(negedge clk); tc_set = 4'b0010;
    @(negedge clk); tc_set = 0;
    rd(4'd8, d); chk("R10 tc set", d, 8'h02);
    rd(4'd8, d); chk("R8 read cleared", d, 8'h00);
    @(negedge clk); tc_set = 4'b0100;
    @(negedge clk); tc_set = 4'b1000; port_rd = 1; port_idx = 4'd8;
    #1 d = port_rdata; chk("R8 status read", d, 8'h04);
    @(negedge clk); tc_set = 0; port_rd = 0;
    rd(4'd8, d); chk("R10 tc beats read", d, 8'h08);
    @(negedge clk); tc_set = 4'b0001; port_wr = 1; port_idx = 4'd9; port_wdata = 8'h04;
    @(negedge clk); tc_set = 0; port_wr = 0;
    rd(4'd8, d); chk("R10 tc beats req write", d, 8'h11);
    rd(4'd12, d); chk("R8 other idx", d, 8'h00);
    rd(4'd3, d);  chk("R8 channel idx", d, 8'h00);
    wr(4'd3, 8'hFF); rd(4'd15, d); chk("R8 low idx write ignored", d, 8'h00);
  endtask

  task automatic t_mode;
    wr(4'd11, 8'hA3);
    chk("R5 mode ch3", mode_flat[31:24], 8'hA3);
    chk("R5 dir", dir_dec, 4'b1000);
    chk("R5 opmode", op_mode[7:6], 2'b10);
    wr(4'd11, 8'h41);
    chk("R5 mode ch1", mode_flat[15:8], 8'h41);
    chk("R5 ch3 kept", mode_flat[31:24], 8'hA3);
  endtask

  task automatic t_pulses;
    logic [7:0] d;
    wr(4'd12, 8'h00);
    chk("R6 ffclr pulse", {ptr_clr, mst_rst}, 2'b10);
    @(negedge clk); chk("R6 ffclr one cycle", ptr_clr, 0);
    wr(4'd8, 8'h04);
    wr(4'd13, 8'h00);
    chk("R6 mrst pulse", {ptr_clr, mst_rst}, 2'b11);
    chk("R6 cmd zero", cmd_reg, 0);
    rd(4'd15, d); chk("R6 mask ones", d, 8'h0F);
    rd(4'd8, d);  chk("R6 status zero", d, 8'h00);
    chk("R6 pulses end", {ptr_clr, mst_rst}, 0);
    chk("R11 svc off", svc_en, 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_cmd; t_req_mask; t_prio; t_dreq; t_tc; t_mode; t_pulses;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule